// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces a repeated-start condition on a pair of open-drain I2C lines. Software requests it by setting the restart-enable bit of a small control register while the master is idle and no byte transfer is running. The sequencer first pulls the clock line low. It then releases the data line for one baud period and releases the clock. It holds both lines high for one baud period, and finally pulls the data line low for one baud period while the clock stays high. After that it raises an interrupt flag, clears the enable bit by itself and leaves the data line held low for the transfer that follows.

Every step waits until the real bus level has been sampled. Timing comes from a down-counter reloaded from a programmable divisor, so one baud period lasts (divisor + 1) system clocks. A slave that stretches the clock simply lengthens the sequence. Two bus-collision cases end the sequence early. In both cases the lines are released, the collision flag is set and the enable bit is cleared. While the sequence runs, writes to the transmit buffer are refused and flagged, and writes to the control register are discarded. A separate detector watches the lines for a start pattern from any source.

Top module: `i2c_rstart_seq`

## Requirements
- R1: After reset both pad outputs are 1 (released). The control register, the transmit buffer and the four flags (`irq`, `bus_coll`, `wr_coll`, `start_seen`) are all 0.
- R2: The restart-enable bit is bit 1 of the control register. A control write that sets it starts a sequence only when the sequencer is idle and `tx_busy` is 0. When `tx_busy` is 1 the bit stays 0 and the lines stay released, while the other control bits still take the written value.
- R3: A sequence drives SCL low first. The data line is released only after SCL has been sampled low, and SCL is released only after SDA has been sampled high. On a bus that follows the pads, `irq` reads 1 exactly 3*(D+1)+2 clocks after the clock edge that accepted the enable write, where D is the divisor. Each clock cycle that another device holds SCL low after its release adds one clock to that figure.
- R4: Before `irq` rises, SDA is driven low while SCL is released for exactly D+1 clocks. When `irq` rises the enable bit reads 0, and SDA stays driven low afterwards.
- R5: `start_seen` is set one clock after the sampled SDA falls while the sampled SCL is high. In a normal sequence this is D clocks before `irq` rises.
- R6: If SDA is sampled low at the moment SCL is first sampled high after its release, `bus_coll` is set. Both pads are released, the enable bit is cleared and `irq` stays 0.
- R7: If SCL is sampled low during the both-lines-high period, the same collision response as in R6 occurs.
- R8: A transmit-buffer write while a sequence runs sets `wr_coll` and leaves `txbuf_q` unchanged. A write while idle updates `txbuf_q` and does not set `wr_coll`.
- R9: Control-register writes (all five bits) made while a sequence runs have no effect.
- R10: A `flags_clr` pulse clears `irq`, `bus_coll`, `wr_coll` and `start_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_busy | input | 1 | A byte transfer is in progress |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write data; bit 1 is the restart enable |
| ctrl_rdata | output | 5 | Control register contents |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 7 | Baud divisor D |
| txbuf_wr | input | 1 | Transmit buffer write strobe |
| txbuf_wdata | input | 8 | Transmit buffer write data |
| txbuf_q | output | 8 | Transmit buffer contents |
| flags_clr | input | 1 | Clears all four flags |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_out | output | 1 | SCL pad: 0 drives low, 1 releases |
| sda_out | output | 1 | SDA pad: 0 drives low, 1 releases |
| start_seen | output | 1 | Start pattern seen on the lines |
| bus_coll | output | 1 | Bus collision flag |
| wr_coll | output | 1 | Transmit-buffer write collision flag |
| irq | output | 1 | Sequence-complete interrupt flag |

## Verification
The hardest cases to reach are the two collision windows. Each is only a few clocks wide, and its position moves with the divisor. The bench models the bus as a wired-AND of the pads and of its own pull-downs. It watches the pads every cycle and pulls a line low at a point it counts from the release of SCL: the data line at the release itself, and the clock line one cycle into the both-high period. Random divisors, clock-stretch lengths and mid-sequence writes to the buffer and the control register exercise the timing and the locking together.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCL_LO,
        ST_SDA_HI,
        ST_SCL_REL,
        ST_BOTH_HI,
        ST_SDA_LO
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sda_hold;
    } seq_regs_t;

endpackage

// File: rtl/rsq_baud_cnt.sv
module rsq_baud_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rsq_start_det.sv
module rsq_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_pulse
);
    logic prev_sda_d, prev_sda_q;

    always_comb begin
        prev_sda_d  = sda_in;
        start_pulse = prev_sda_q && !sda_in && scl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_sda_q <= 1'b1;
        else        prev_sda_q <= prev_sda_d;
    end
endmodule

// File: rtl/rsq_seq_fsm.sv
module rsq_seq_fsm
    import rsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic scl_in,
    input  logic sda_in,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic scl_out,
    output logic sda_out,
    output logic active,
    output logic done,
    output logic coll
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        done     = 1'b0;
        coll     = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (go) r_d.state = ST_SCL_LO;
            end
            ST_SCL_LO: begin
                if (!scl_in) begin
                    r_d.state = ST_SDA_HI;
                    cnt_load  = 1'b1;
                end
            end
            ST_SDA_HI: begin
                if (cnt_zero && sda_in) r_d.state = ST_SCL_REL;
            end
            ST_SCL_REL: begin
                if (scl_in) begin
                    if (!sda_in) begin
                        coll         = 1'b1;
                        r_d.state    = ST_IDLE;
                        r_d.sda_hold = 1'b1;
                    end else begin
                        r_d.state = ST_BOTH_HI;
                        cnt_load  = 1'b1;
                    end
                end
            end
            ST_BOTH_HI: begin
                if (!scl_in) begin
                    coll         = 1'b1;
                    r_d.state    = ST_IDLE;
                    r_d.sda_hold = 1'b1;
                end else if (cnt_zero) begin
                    r_d.state = ST_SDA_LO;
                    cnt_load  = 1'b1;
                end
            end
            ST_SDA_LO: begin
                if (cnt_zero) begin
                    done         = 1'b1;
                    r_d.state    = ST_IDLE;
                    r_d.sda_hold = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.sda_hold <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        active  = (r_q.state != ST_IDLE);
        scl_out = !((r_q.state == ST_SCL_LO) || (r_q.state == ST_SDA_HI));
        if (r_q.state == ST_SDA_LO)
            sda_out = 1'b0;
        else if ((r_q.state == ST_IDLE) || (r_q.state == ST_SCL_LO))
            sda_out = r_q.sda_hold;
        else
            sda_out = 1'b1;
    end
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq #(
    parameter int CTRL_W   = 5,
    parameter int RSEN_BIT = 1,
    parameter int DIV_W    = 7,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_busy,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              txbuf_wr,
    input  logic [DATA_W-1:0] txbuf_wdata,
    output logic [DATA_W-1:0] txbuf_q,
    input  logic              flags_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic              start_seen,
    output logic              bus_coll,
    output logic              wr_coll,
    output logic              irq
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] txbuf;
        logic              irq;
        logic              bus_coll;
        logic              wr_coll;
        logic              start_seen;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic go, seq_active, seq_done, seq_coll, cnt_load, cnt_zero, start_pulse;

    rsq_baud_cnt #(.CNT_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (r_q.div),
        .zero     (cnt_zero)
    );

    rsq_start_det u_sdet (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .start_pulse (start_pulse)
    );

    rsq_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .scl_out  (scl_out),
        .sda_out  (sda_out),
        .active   (seq_active),
        .done     (seq_done),
        .coll     (seq_coll)
    );

    always_comb begin
        r_d = r_q;
        go  = ctrl_wr && ctrl_wdata[RSEN_BIT] && !seq_active && !tx_busy;

        // control register: locked while the sequence runs
        if (ctrl_wr && !seq_active) begin
            r_d.ctrl = ctrl_wdata;
            if (tx_busy) r_d.ctrl[RSEN_BIT] = 1'b0;
        end
        if (seq_done || seq_coll) r_d.ctrl[RSEN_BIT] = 1'b0;

        if (div_wr) r_d.div = div_wdata;

        if (flags_clr) begin
            r_d.irq        = 1'b0;
            r_d.bus_coll   = 1'b0;
            r_d.wr_coll    = 1'b0;
            r_d.start_seen = 1'b0;
        end

        if (txbuf_wr) begin
            if (seq_active) r_d.wr_coll = 1'b1;
            else            r_d.txbuf   = txbuf_wdata;
        end
        if (seq_done)    r_d.irq        = 1'b1;
        if (seq_coll)    r_d.bus_coll   = 1'b1;
        if (start_pulse) r_d.start_seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_rdata = r_q.ctrl;
    assign txbuf_q    = r_q.txbuf;
    assign irq        = r_q.irq;
    assign bus_coll   = r_q.bus_coll;
    assign wr_coll    = r_q.wr_coll;
    assign start_seen = r_q.start_seen;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk #(
    parameter int CTRL_W   = 5,
    parameter int RSEN_BIT = 1,
    parameter int DATA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              tx_busy,
    input logic              txbuf_wr,
    input logic              seq_active,
    input logic [CTRL_W-1:0] ctrl_rdata,
    input logic [DATA_W-1:0] txbuf_q,
    input logic              scl_out,
    input logic              sda_out,
    input logic              irq,
    input logic              bus_coll,
    input logic              wr_coll
);
    localparam logic [CTRL_W-1:0] RSEN_MASK = CTRL_W'(1) << RSEN_BIT;

    assert_busy_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && tx_busy && !seq_active) |=> !ctrl_rdata[RSEN_BIT]);

    assert_scl_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_active) |-> !scl_out);

    assert_enable_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active |-> ctrl_rdata[RSEN_BIT]);

    assert_finish_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!sda_out && scl_out && !ctrl_rdata[RSEN_BIT]));

    assert_coll_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (scl_out && sda_out && !ctrl_rdata[RSEN_BIT]));

    assert_txbuf_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && txbuf_wr) |=> ($stable(txbuf_q) && wr_coll));

    assert_ctrl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && ctrl_wr) |=>
            ((ctrl_rdata | RSEN_MASK) == ($past(ctrl_rdata) | RSEN_MASK)));
endmodule

bind i2c_rstart_seq rsq_chk #(
    .CTRL_W   (CTRL_W),
    .RSEN_BIT (RSEN_BIT),
    .DATA_W   (DATA_W)
) u_rsq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .tx_busy    (tx_busy),
    .txbuf_wr   (txbuf_wr),
    .seq_active (seq_active),
    .ctrl_rdata (ctrl_rdata),
    .txbuf_q    (txbuf_q),
    .scl_out    (scl_out),
    .sda_out    (sda_out),
    .irq        (irq),
    .bus_coll   (bus_coll),
    .wr_coll    (wr_coll)
);

// File: tb/tb_i2c_rstart_seq.sv
module tb_i2c_rstart_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_busy = 1'b0;
    logic ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [4:0] ctrl_rdata;
    logic div_wr = 1'b0;
    logic [6:0] div_wdata = '0;
    logic txbuf_wr = 1'b0;
    logic [7:0] txbuf_wdata = '0;
    logic [7:0] txbuf_q;
    logic flags_clr = 1'b0;
    logic ext_scl = 1'b1;
    logic ext_sda = 1'b1;
    logic scl_in, sda_in, scl_out, sda_out;
    logic start_seen, bus_coll, wr_coll, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // wired-AND bus
    assign scl_in = scl_out & ext_scl;
    assign sda_in = sda_out & ext_sda;

    i2c_rstart_seq dut (
        .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata), .txbuf_q(txbuf_q),
        .flags_clr(flags_clr), .scl_in(scl_in), .sda_in(sda_in),
        .scl_out(scl_out), .sda_out(sda_out), .start_seen(start_seen),
        .bus_coll(bus_coll), .wr_coll(wr_coll), .irq(irq)
    );

    function automatic int exp_latency(int d, int k);
        return 3 * (d + 1) + 2 + k;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk) flags_clr = 1'b1;
        @(negedge clk) flags_clr = 1'b0;
    endtask

    task automatic set_div(int d);
        @(negedge clk) begin div_wr = 1'b1; div_wdata = 7'(d); end
        @(negedge clk) div_wr = 1'b0;
    endtask

    task automatic write_go();
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_wdata = 5'b00010; end
        @(negedge clk) ctrl_wr = 1'b0;
    endtask

    // normal sequence with optional stretch and mid-sequence writes
    task automatic run_seq(int d, int k, bit do_tx, bit do_ctl);
        int lat = 0, sdalo = 0, ss_at = -1, stretch = 0;
        bit seen_rel = 1'b0;
        logic [7:0] old_buf = txbuf_q;
        set_div(d);
        clear_flags();
        write_go();
        lat = 1;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (irq) break;
            if (!sda_out && scl_out) sdalo++;
            if (start_seen && ss_at < 0) ss_at = lat;
            if (scl_out && !seen_rel) begin seen_rel = 1'b1; stretch = k; end
            if (stretch > 0) begin ext_scl = 1'b0; stretch--; end
            else ext_scl = 1'b1;
            txbuf_wr = do_tx && (lat == 2);
            txbuf_wdata = 8'($urandom);
            ctrl_wr = do_ctl && (lat == 3);
            ctrl_wdata = 5'b11101;
            @(negedge clk);
            lat++;
        end
        txbuf_wr = 1'b0; ctrl_wr = 1'b0; ext_scl = 1'b1;
        if (ss_at < 0 && start_seen) ss_at = lat;
        chk("R3 latency", lat - 1, exp_latency(d, k));
        chk("R4 sda-low phase", sdalo, d + 1);
        chk("R5 start_seen lead", lat - ss_at, d);
        chk("R4 enable cleared", int'(ctrl_rdata), 0);
        if (do_ctl) chk("R9 ctrl locked", int'(ctrl_rdata), 0);
        if (do_tx) begin
            chk("R8 wr_coll", int'(wr_coll), 1);
            chk("R8 buffer kept", int'(txbuf_q), int'(old_buf));
        end
        repeat (3) @(negedge clk);
        chk("R4 sda held low", int'(sda_out), 0);
        chk("R4 scl released", int'(scl_out), 1);
    endtask

    task automatic check_coll(string req);
        repeat (4) @(negedge clk);
        chk({req, " bus_coll"}, int'(bus_coll), 1);
        chk({req, " irq"}, int'(irq), 0);
        chk({req, " scl"}, int'(scl_out), 1);
        chk({req, " sda"}, int'(sda_out), 1);
        chk({req, " enable"}, int'(ctrl_rdata[1]), 0);
        ext_scl = 1'b1; ext_sda = 1'b1;
    endtask

    // SDA pulled low when SCL is released
    task automatic run_coll_sda(int d);
        set_div(d);
        clear_flags();
        write_go();
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (scl_out) begin ext_sda = 1'b0; break; end
            @(negedge clk);
        end
        check_coll("R6");
    endtask

    // SCL pulled low one cycle into the both-high period
    task automatic run_coll_scl(int d);
        int n = 0;
        set_div(d);
        clear_flags();
        write_go();
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (scl_out) n++;
            if (n == 2) begin ext_scl = 1'b0; break; end
            @(negedge clk);
        end
        @(negedge clk) ext_scl = 1'b1;
        check_coll("R7");
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c2d));
        repeat (3) @(negedge clk);
        chk("R1 scl_out", int'(scl_out), 1);
        chk("R1 sda_out", int'(sda_out), 1);
        chk("R1 flags", int'({irq, bus_coll, wr_coll, start_seen}), 0);
        chk("R1 ctrl", int'(ctrl_rdata), 0);
        chk("R1 txbuf", int'(txbuf_q), 0);
        @(negedge clk) rst_n = 1'b1;

        // R8 idle write
        @(negedge clk) begin txbuf_wr = 1'b1; txbuf_wdata = 8'hA5; end
        @(negedge clk) txbuf_wr = 1'b0;
        chk("R8 idle write", int'(txbuf_q), 8'hA5);
        chk("R8 no wr_coll idle", int'(wr_coll), 0);

        // R2 enable ignored while transmitting
        tx_busy = 1'b1;
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_wdata = 5'b00011; end
        @(negedge clk) ctrl_wr = 1'b0;
        chk("R2 busy ctrl", int'(ctrl_rdata), 5'b00001);
        repeat (5) @(negedge clk);
        chk("R2 scl idle", int'(scl_out), 1);
        tx_busy = 1'b0;
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_wdata = 5'b00000; end
        @(negedge clk) ctrl_wr = 1'b0;

        // directed corners
        run_seq(0, 0, 1'b0, 1'b0);
        run_seq(1, 0, 1'b1, 1'b1);
        run_seq(5, 3, 1'b0, 1'b0);
        run_seq(127, 0, 1'b1, 1'b0);

        // R10 flag clear
        clear_flags();
        chk("R10 flags cleared", int'({irq, bus_coll, wr_coll, start_seen}), 0);

        // random runs
        for (int i = 0; i < 20; i++) begin
            run_seq(int'($urandom_range(0, 15)), int'($urandom_range(0, 5)),
                    1'($urandom), 1'($urandom));
        end

        run_coll_sda(3);
        run_coll_sda(0);
        run_coll_scl(4);
        run_coll_scl(1);

        // recovers after a collision
        run_seq(2, 0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule